// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block sits in an Ethernet receive path and decides, from the destination MAC address alone, whether a frame should be kept. The six destination bytes arrive one per cycle on a byte stream whose first byte is marked by a start flag. The block runs an Ethernet CRC-32 over them, least-significant bit of each byte first. It turns the result into an 8-bit hash index and looks that index up in a 256-entry group table. One cycle after the sixth byte it presents a single-cycle verdict: the index, whether the table hit, whether the address was broadcast or not multicast at all, and the final accept decision.

The 256 table entries are held as eight 32-bit words, with entries numbered from the most significant bit of word 0 to the least significant bit of word 7. Software fills the table in two ways. A word port overwrites one whole 32-bit word. A helper port takes a complete six-byte address and a set/clear flag, hashes the address with the same CRC function the receive check uses, and sets or clears the one entry it maps to. A single bypass input forces acceptance of every frame.

Top module: `mcast_hash_filter`

## Requirements
- R1: A synchronous reset clears every table entry and holds `res_valid`, `res_accept` and `res_hash_hit` low. After reset, no multicast frame other than broadcast is accepted until the table is written.
- R2: `res_valid` pulses for exactly one cycle, in the cycle after the sixth address byte is taken. In that cycle `res_index` equals the top 8 bits of the bit-reversed CRC-32 of the six bytes. The CRC uses polynomial 0x04C11DB7, starts from all ones, applies no final inversion, and takes each byte LSB first. Outside that pulse, `res_accept` and `res_hash_hit` are low.
- R3: Entry e lives in word e/32 at bit position 31 - (e mod 32). Entry 0 is bit 31 of word 0 and entry 255 is bit 0 of word 7. A frame whose index selects a set entry reports `res_hash_hit` and `res_accept`.
- R4: A word write (`cfg_wr_en`) replaces all 32 bits of the word selected by `cfg_wr_sel` with `cfg_wr_data`.
- R5: A helper command with `hlp_set`=1 sets the entry that `hlp_addr` hashes to and leaves every other entry unchanged. Byte 0, the first one on the wire, is `hlp_addr[47:40]`.
- R6: A helper command with `hlp_set`=0 clears only that entry.
- R7: The address is multicast when bit 0 of its first byte is 1. A non-multicast address sets `res_ucast` and never reports `res_hash_hit`, whatever the table holds.
- R8: An address of all ones sets `res_bcast` and is accepted regardless of the table. An address that is all ones except for one bit is not broadcast.
- R9: When `promisc` is high in the cycle the sixth byte is taken, the frame is accepted whatever its address.
- R10: Bytes that arrive after the sixth, and before the next start flag, are ignored and produce no result. A start flag in the middle of an address restarts the hash. Idle cycles between address bytes are allowed.
- R11: When a word write and a helper command arrive in the same cycle, the helper's bit change is applied on top of the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_sof | input | 1 | Marks the first destination byte |
| rx_byte | input | 8 | Receive byte |
| promisc | input | 1 | Accept-all bypass |
| cfg_wr_en | input | 1 | Whole-word table write |
| cfg_wr_sel | input | 3 | Word number for the word write |
| cfg_wr_data | input | 32 | Word write data |
| hlp_valid | input | 1 | Helper set/clear command |
| hlp_set | input | 1 | 1 sets, 0 clears the hashed entry |
| hlp_addr | input | 48 | Address to hash, first byte in bits 47:40 |
| res_valid | output | 1 | Verdict strobe |
| res_index | output | 8 | Hash index of the address |
| res_hash_hit | output | 1 | Multicast address hit a set table entry |
| res_bcast | output | 1 | Address was all ones |
| res_ucast | output | 1 | Address was not multicast |
| res_accept | output | 1 | Final keep decision |

## Verification
The bench targets the two ends of the table, entries 0 and 255, and their neighbours. A design that counted bits from the LSB, or swapped the word and bit fields of the index, would hit on the neighbour instead. It checks that a helper clear leaves a nearby entry in the same word set, which an overwrite of the whole word would destroy. It also checks a word write and a helper set landing in the same word in the same cycle, where a wrong priority loses one of the two. Stream corner cases include extra bytes after the address, a restart part-way through an address, and idle gaps between bytes. Each of these would produce either a spurious second verdict or an index hashed over the wrong bytes.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  // Advance a non-reflected CRC register by one byte taken LSB first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in,
                                           input logic [7:0]  d,
                                           input logic [31:0] poly);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/mhf_hash_engine.sv
module mhf_hash_engine #(
  parameter int          ADDR_BYTES = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_byte,
  output logic        done,
  output logic [31:0] crc_out,
  output logic        grp_out,
  output logic        bc_out
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(ADDR_BYTES);

  logic [31:0]   crc_q;
  logic [CW-1:0] cnt_q;
  logic          grp_q, bc_q;

  logic [31:0]   crc_base;
  logic [CW-1:0] cnt_base;
  logic          take;

  always_comb begin
    crc_base = rx_sof ? '1 : crc_q;
    cnt_base = rx_sof ? '0 : cnt_q;
    take     = rx_valid && (rx_sof || (cnt_q != '0 && cnt_q != FULL_CNT));
    crc_out  = mhf_pkg::crc_byte(crc_base, rx_byte, CRC_POLY);
    grp_out  = rx_sof ? rx_byte[0] : grp_q;
    bc_out   = (rx_sof ? 1'b1 : bc_q) & (rx_byte == 8'hFF);
    done     = take && (cnt_base == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '1;
      cnt_q <= '0;
      grp_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (take) begin
      crc_q <= crc_out;
      cnt_q <= cnt_base + CW'(1);
      grp_q <= grp_out;
      bc_q  <= bc_out;
    end
  end
endmodule

// File: rtl/mhf_addr_hasher.sv
module mhf_addr_hasher #(
  parameter int          ADDR_BYTES = 6,
  parameter int          IDX_W      = 8,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
  input  logic [8*ADDR_BYTES-1:0] addr,
  output logic [IDX_W-1:0]        idx
);
  logic [31:0] c;
  logic [31:0] r;

  always_comb begin
    c = '1;
    for (int i = 0; i < ADDR_BYTES; i++)
      c = mhf_pkg::crc_byte(c, addr[8*(ADDR_BYTES-1-i) +: 8], CRC_POLY);
    r   = mhf_pkg::rev32(c);
    idx = r[31 -: IDX_W];
  end
endmodule

// File: rtl/mhf_group_table.sv
module mhf_group_table #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic [$clog2(NUM_WORDS)-1:0]           wr_sel,
  input  logic [WORD_W-1:0]                      wr_data,
  input  logic                                   bit_en,
  input  logic                                   bit_set,
  input  logic [$clog2(NUM_WORDS*WORD_W)-1:0]    bit_idx,
  input  logic [$clog2(NUM_WORDS*WORD_W)-1:0]    lk_idx,
  output logic                                   lk_hit
);
  localparam int WSEL_W = $clog2(NUM_WORDS);
  localparam int BSEL_W = $clog2(WORD_W);
  localparam int IDX_W  = WSEL_W + BSEL_W;
  localparam logic [BSEL_W-1:0] TOP_POS = BSEL_W'(WORD_W - 1);

  logic [WORD_W-1:0] tbl_q [NUM_WORDS];

  logic [WSEL_W-1:0] bit_word, lk_word;
  logic [BSEL_W-1:0] bit_pos, lk_pos;
  logic [WORD_W-1:0] bit_mask;

  always_comb begin
    bit_word = bit_idx[IDX_W-1 -: WSEL_W];
    bit_pos  = TOP_POS - bit_idx[BSEL_W-1:0];
    bit_mask = {{(WORD_W-1){1'b0}}, 1'b1} << bit_pos;
    lk_word  = lk_idx[IDX_W-1 -: WSEL_W];
    lk_pos   = TOP_POS - lk_idx[BSEL_W-1:0];
    lk_hit   = tbl_q[lk_word][lk_pos];
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] nxt;
    always_comb begin
      nxt = tbl_q[w];
      if (wr_en && wr_sel == WSEL_W'(w)) nxt = wr_data;
      if (bit_en && bit_word == WSEL_W'(w))
        nxt = bit_set ? (nxt | bit_mask) : (nxt & ~bit_mask);
    end
    always_ff @(posedge clk) begin
      if (rst) tbl_q[w] <= '0;
      else     tbl_q[w] <= nxt;
    end
  end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int          NUM_WORDS  = 8,
  parameter int          WORD_W     = 32,
  parameter int          ADDR_BYTES = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                rx_valid,
  input  logic                                rx_sof,
  input  logic [7:0]                          rx_byte,
  input  logic                                promisc,
  input  logic                                cfg_wr_en,
  input  logic [$clog2(NUM_WORDS)-1:0]        cfg_wr_sel,
  input  logic [WORD_W-1:0]                   cfg_wr_data,
  input  logic                                hlp_valid,
  input  logic                                hlp_set,
  input  logic [8*ADDR_BYTES-1:0]             hlp_addr,
  output logic                                res_valid,
  output logic [$clog2(NUM_WORDS*WORD_W)-1:0] res_index,
  output logic                                res_hash_hit,
  output logic                                res_bcast,
  output logic                                res_ucast,
  output logic                                res_accept
);
  localparam int IDX_W = $clog2(NUM_WORDS * WORD_W);

  logic             done;
  logic [31:0]      crc_fin, crc_rev;
  logic             grp, bc;
  logic [IDX_W-1:0] rx_idx, hlp_idx;
  logic             tbl_hit;

  mhf_hash_engine #(.ADDR_BYTES(ADDR_BYTES), .CRC_POLY(CRC_POLY)) u_eng (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .done(done), .crc_out(crc_fin),
    .grp_out(grp), .bc_out(bc)
  );

  always_comb begin
    crc_rev = mhf_pkg::rev32(crc_fin);
    rx_idx  = crc_rev[31 -: IDX_W];
  end

  mhf_addr_hasher #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W), .CRC_POLY(CRC_POLY)) u_hlp (
    .addr(hlp_addr), .idx(hlp_idx)
  );

  mhf_group_table #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .bit_en(hlp_valid), .bit_set(hlp_set), .bit_idx(hlp_idx),
    .lk_idx(rx_idx), .lk_hit(tbl_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_index    <= '0;
      res_hash_hit <= 1'b0;
      res_bcast    <= 1'b0;
      res_ucast    <= 1'b0;
      res_accept   <= 1'b0;
    end else begin
      res_valid    <= done;
      res_index    <= done ? rx_idx : '0;
      res_hash_hit <= done & grp & tbl_hit;
      res_bcast    <= done & bc;
      res_ucast    <= done & ~grp;
      res_accept   <= done & (promisc | bc | (grp & tbl_hit));
    end
  end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
  input logic clk,
  input logic rst,
  input logic promisc,
  input logic res_valid,
  input logic res_hash_hit,
  input logic res_bcast,
  input logic res_ucast,
  input logic res_accept
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid && !res_accept);                          // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);                                          // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_accept && !res_hash_hit);                       // R2
  AST_HIT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_hash_hit |-> res_accept);                          // R3
  AST_UCAST_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_ucast |-> !res_hash_hit && !res_bcast);            // R7
  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_bcast |-> res_accept);                             // R8
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    res_valid && $past(promisc) |-> res_accept);                        // R9
endmodule

bind mcast_hash_filter mhf_checker u_chk (
  .clk(clk), .rst(rst), .promisc(promisc), .res_valid(res_valid),
  .res_hash_hit(res_hash_hit), .res_bcast(res_bcast),
  .res_ucast(res_ucast), .res_accept(res_accept)
);

// File: tb/sim_mcast_hash_filter.sv
module sim_mcast_hash_filter;
  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid, rx_sof, promisc;
  logic [7:0]  rx_byte;
  logic        cfg_wr_en;
  logic [2:0]  cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic        hlp_valid, hlp_set;
  logic [47:0] hlp_addr;
  logic        res_valid, res_hash_hit, res_bcast, res_ucast, res_accept;
  logic [7:0]  res_index;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mcast_hash_filter u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .promisc(promisc), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .hlp_valid(hlp_valid), .hlp_set(hlp_set), .hlp_addr(hlp_addr),
    .res_valid(res_valid), .res_index(res_index),
    .res_hash_hit(res_hash_hit), .res_bcast(res_bcast),
    .res_ucast(res_ucast), .res_accept(res_accept)
  );

  // {address, promisc, expected bcast, expected ucast, expected accept}
  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {48'h0011_2233_4455, 1'b0, 1'b0, 1'b1, 1'b0},
    {48'h0100_5E00_0001, 1'b0, 1'b0, 1'b0, 1'b0},
    {48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1},
    {48'h0011_2233_4455, 1'b1, 1'b0, 1'b1, 1'b1},
    {48'h0100_5E7F_FFFA, 1'b1, 1'b0, 1'b0, 1'b1},
    {48'h3333_0000_0001, 1'b0, 1'b0, 1'b0, 1'b0},
    {48'hFFFF_FFFF_FFFE, 1'b0, 1'b0, 1'b0, 1'b0},
    {48'hFEFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  // Reference hash: reflected CRC-32, index is the top byte of the register.
  function automatic logic [7:0] ref_idx(input logic [47:0] a);
    logic [31:0] r = '1;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        if (r[0] ^ b[j]) r = (r >> 1) ^ 32'hEDB88320;
        else             r = r >> 1;
      end
    end
    return r[31:24];
  endfunction

  function automatic logic [47:0] find_addr(input logic [7:0] target);
    for (int k = 0; k < 65536; k++) begin
      logic [47:0] a = {32'h0100_5E00, 16'(k)};
      if (ref_idx(a) == target) return a;
    end
    return 48'h0100_5E00_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drives six bytes (optionally with idle gaps) and samples the verdict.
  task automatic send(input logic [47:0] a, input logic pm, input bit gaps);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_byte  = a[47-8*i -: 8];
      promisc  = pm;
      if (gaps && i < 5) begin
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_sof   = 1'b0;
    promisc  = 1'b0;
  endtask

  task automatic helper(input logic [47:0] a, input logic s);
    @(negedge clk);
    hlp_valid = 1'b1; hlp_set = s; hlp_addr = a;
    @(negedge clk);
    hlp_valid = 1'b0;
  endtask

  task automatic wword(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [47:0] a, input logic hit);
    send(a, 1'b0, 1'b0);
    chk({tag, " valid"}, 32'(res_valid), 32'd1);
    chk({tag, " hit"}, 32'(res_hash_hit), 32'(hit));
    chk({tag, " accept"}, 32'(res_accept), 32'(hit));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] a_addr, b_addr, c_addr, d_addr;
    logic [7:0]  ia, ic;
    rst = 1'b1; rx_valid = 0; rx_sof = 0; rx_byte = 0; promisc = 0;
    cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = 0;
    hlp_valid = 0; hlp_set = 0; hlp_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset valid", 32'(res_valid), 32'd0);
    chk("R1 reset accept", 32'(res_accept), 32'd0);

    // Vector walk on an empty table: R2 index, R7 group bit, R8 broadcast, R9 bypass
    for (int v = 0; v < NV; v++) begin
      logic [51:0] e = VEC[v];
      send(e[51:4], e[3], 1'b0);
      chk("R2 valid", 32'(res_valid), 32'd1);
      chk("R2 index", 32'(res_index), 32'(ref_idx(e[51:4])));
      chk("R8 bcast", 32'(res_bcast), 32'(e[2]));
      chk("R7 ucast", 32'(res_ucast), 32'(e[1]));
      chk("R9 accept", 32'(res_accept), 32'(e[0]));
      chk("R1 empty table no hit", 32'(res_hash_hit), 32'd0);
      @(negedge clk);
      chk("R2 pulse ends", 32'(res_valid), 32'd0);
    end

    // R5 / R6 helper set and clear
    a_addr = 48'h0100_5E00_0001;
    ia     = ref_idx(a_addr);
    b_addr = find_addr(ia ^ 8'h01);
    helper(a_addr, 1'b1);
    expect_hit("R5 set entry", a_addr, 1'b1);
    expect_hit("R5 neighbour untouched", b_addr, 1'b0);
    helper(b_addr, 1'b1);
    helper(a_addr, 1'b0);
    expect_hit("R6 cleared entry", a_addr, 1'b0);
    expect_hit("R6 neighbour kept", b_addr, 1'b1);

    // R7: a unicast address whose index would hit still reports no hit
    c_addr = 48'h0000_0000_0000;
    helper(c_addr, 1'b1);
    send(c_addr, 1'b0, 1'b0);
    chk("R7 ucast no hit", 32'(res_hash_hit), 32'd0);
    chk("R7 ucast reject", 32'(res_accept), 32'd0);

    // R4 word writes and R3 bit mapping at both ends of the table
    for (int w = 0; w < 8; w++) wword(3'(w), 32'h0);
    expect_hit("R4 word cleared", b_addr, 1'b0);
    wword(3'd0, 32'h8000_0000);
    expect_hit("R3 entry 0 is word0 MSB", find_addr(8'd0), 1'b1);
    expect_hit("R3 entry 1 clear", find_addr(8'd1), 1'b0);
    wword(3'd7, 32'h0000_0001);
    expect_hit("R3 entry 255 is word7 LSB", find_addr(8'd255), 1'b1);
    expect_hit("R3 entry 254 clear", find_addr(8'd254), 1'b0);
    wword(3'd2, 32'hFFFF_FFFF);
    expect_hit("R4 full word", find_addr(8'd77), 1'b1);
    expect_hit("R4 next word untouched", find_addr(8'd96), 1'b0);

    // R11: word write and helper set in the same cycle
    ic     = 8'd100;
    c_addr = find_addr(ic);
    d_addr = find_addr(8'd101);
    wword(3'd3, 32'hFFFF_FFFF);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 3'd3; cfg_wr_data = 32'h0;
    hlp_valid = 1'b1; hlp_set = 1'b1; hlp_addr = c_addr;
    @(negedge clk);
    cfg_wr_en = 1'b0; hlp_valid = 1'b0;
    expect_hit("R11 helper bit survives", c_addr, 1'b1);
    expect_hit("R11 word write applied", d_addr, 1'b0);

    // R10: trailing bytes ignored, restart mid-address, gaps between bytes
    send(c_addr, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'hA5;
      @(negedge clk);
      chk("R10 no result from trailing bytes", 32'(res_valid), 32'd0);
    end
    rx_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = 8'h5A;
    end
    send(c_addr, 1'b0, 1'b0);
    chk("R10 restart index", 32'(res_index), 32'(ic));
    chk("R10 restart hit", 32'(res_hash_hit), 32'd1);
    send(c_addr, 1'b0, 1'b1);
    chk("R10 gapped valid", 32'(res_valid), 32'd1);
    chk("R10 gapped index", 32'(res_index), 32'(ic));

    // R1: reset clears a populated table
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expect_hit("R1 table cleared", c_addr, 1'b0);
    send(48'hFFFF_FFFF_FFFF, 1'b0, 1'b0);
    chk("R8 bcast after reset", 32'(res_accept), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule